// File: doc/BRIEF.md
# Converter Calibration Mode Sequencer

This block is the control logic that runs calibration cycles for a sigma-delta converter channel set. A host writes a 3-bit mode code. The code is held as pending and takes effect on the next modulator tick. Two codes start a calibration: one measures zero scale and one measures full scale. While a calibration runs, the ready flag is high. The block counts completed filter outputs, and the calibration length depends on the chop-enable input. On the last output it stores that result into the offset or gain coefficient of the channel that was selected when the command was accepted. It then drops ready and returns the mode to idle.

Conversion codes are stored as the current mode and start nothing here. After any calibration, a conversion must be commanded again. A mode write that lands during a calibration cancels it without touching any coefficient. A read port returns both coefficients of any channel.

Top module: `calSequencer`

## Requirements
- R1: While reset (`rstN` low) is sampled at a clock edge, the mode goes to 000 and ready goes low. The mode stays 000 until a new command is applied. Every offset coefficient resets to 0 and every gain coefficient resets to 0x800000.
- R2: A mode write is held as pending. It is applied at the first clock edge after the write cycle at which `modTick` is high. Before that edge, `mode` keeps its old value.
- R3: When code 100 is applied, `mode` reads 100 and `rdy` is high from that edge onward. `rdy` rises only at an edge where `modTick` is high.
- R4: The calibration length is sampled from `chopEn` at acceptance: 22 filter outputs when it is 1, and 24 when it is 0. At the edge of the last `filtValid`, `rdy` falls, `mode` becomes 000, and for a 100 command the offset of the channel takes that cycle's `filtData`.
- R5: Code 101 runs the same sequence, but the final `filtData` goes into the gain coefficient of the channel, and the offset is unchanged.
- R6: `chanSel` is sampled when a calibration command is applied. Changes to `chanSel` or `chopEn` during the cycle have no effect on which coefficient is written or on the length.
- R7: Codes other than 100 and 101 (001 and 010 being conversions) are stored in `mode` with `rdy` low. After a calibration ends, `mode` stays 000 until a new command is applied.
- R8: A command applied while a calibration runs ends it at that edge. `rdy` goes low unless the new code is itself a calibration, `mode` takes the new code, and no coefficient changes.
- R9: A `filtValid` outside a calibration, or in the same cycle as the command being applied, changes no coefficient and does not count toward the length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| modeWrEn | input | 1 | Host mode write strobe |
| modeWrData | input | 3 | Mode code written |
| modTick | input | 1 | One-cycle modulator tick |
| chopEn | input | 1 | Chopping enable, selects calibration length |
| chanSel | input | 2 | Selected channel |
| filtValid | input | 1 | Filter output strobe (one per output period) |
| filtData | input | 24 | Filter output word |
| rdChan | input | 2 | Channel whose coefficients are read |
| mode | output | 3 | Current mode code |
| rdy | output | 1 | High while a calibration runs |
| rdOffset | output | 24 | Offset coefficient of `rdChan` |
| rdGain | output | 24 | Gain coefficient of `rdChan` |

## Verification
A stale period counter shows up as `rdy` falling one or two strobes early or late. This appears at the last filter output of the cycle, together with a coefficient that holds the wrong strobe's data. A wrong latched channel or a wrong gain/offset selector writes the wrong coefficient word. This is visible on the read port in the cycle after completion. A lost or early pending command shows up as `mode` changing on the wrong edge, at most one tick away from the expected one. Because the reference is compared every cycle, each of these faults is caught at the first edge where it occurs.

// File: rtl/calSeqPkg.sv
package calSeqPkg;
  localparam logic [2:0] MODE_IDLE   = 3'b000;
  localparam logic [2:0] MODE_ZS_CAL = 3'b100;
  localparam logic [2:0] MODE_FS_CAL = 3'b101;

  // strobes from control to coefficient storage
  typedef struct packed {
    logic wrOffset;
    logic wrGain;
  } coefStrobeT;

  function automatic logic isCalCode(input logic [2:0] code);
    return code[2:1] == 2'b10;
  endfunction
endpackage

// File: rtl/calCtrl.sv
module calCtrl
  import calSeqPkg::*;
#(
  parameter int CH_W          = 2,
  parameter int CHOP_PERIODS  = 22,
  parameter int PLAIN_PERIODS = 24
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            modeWrEn,
  input  logic [2:0]      modeWrData,
  input  logic            modTick,
  input  logic            chopEn,
  input  logic [CH_W-1:0] chanSel,
  input  logic            filtValid,
  output logic [2:0]      mode,
  output logic            rdy,
  output logic [CH_W-1:0] calChan,
  output coefStrobeT      strb
);
  localparam int MAX_PERIODS = (CHOP_PERIODS > PLAIN_PERIODS) ? CHOP_PERIODS : PLAIN_PERIODS;
  localparam int CNT_W = $clog2(MAX_PERIODS);
  localparam logic [CNT_W-1:0] CHOP_LAST  = CNT_W'(CHOP_PERIODS - 1);
  localparam logic [CNT_W-1:0] PLAIN_LAST = CNT_W'(PLAIN_PERIODS - 1);

  logic             pendValid;
  logic [2:0]       pendCode;
  logic [2:0]       modeQ;
  logic             busy;
  logic             isGain;
  logic [CH_W-1:0]  chanQ;
  logic [CNT_W-1:0] lastIdx;
  logic [CNT_W-1:0] cnt;
  logic             applyCmd;
  logic             lastHit;

  assign applyCmd = modTick && pendValid;
  assign lastHit  = busy && filtValid && !applyCmd && (cnt == lastIdx);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendCode  <= MODE_IDLE;
      modeQ     <= MODE_IDLE;
      busy      <= 1'b0;
      isGain    <= 1'b0;
      chanQ     <= '0;
      lastIdx   <= PLAIN_LAST;
      cnt       <= '0;
    end else begin
      if (applyCmd) begin
        modeQ     <= pendCode;
        pendValid <= 1'b0;
        busy      <= isCalCode(pendCode);
        if (isCalCode(pendCode)) begin
          isGain  <= pendCode[0];
          chanQ   <= chanSel;
          lastIdx <= chopEn ? CHOP_LAST : PLAIN_LAST;
          cnt     <= '0;
        end
      end else if (busy && filtValid) begin
        if (lastHit) begin
          busy  <= 1'b0;
          modeQ <= MODE_IDLE;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      if (modeWrEn) begin
        pendValid <= 1'b1;
        pendCode  <= modeWrData;
      end
    end
  end

  assign mode          = modeQ;
  assign rdy           = busy;
  assign calChan       = chanQ;
  assign strb.wrOffset = lastHit && !isGain;
  assign strb.wrGain   = lastHit && isGain;
endmodule

// File: rtl/calCoefRegs.sv
module calCoefRegs
  import calSeqPkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 24
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  coefStrobeT                strb,
  input  logic [$clog2(NUM_CH)-1:0] wrChan,
  input  logic [DATA_W-1:0]         wrData,
  input  logic [$clog2(NUM_CH)-1:0] rdChan,
  output logic [DATA_W-1:0]         rdOffset,
  output logic [DATA_W-1:0]         rdGain
);
  localparam logic [DATA_W-1:0] GAIN_INIT = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] offsetQ [NUM_CH];
  logic [DATA_W-1:0] gainQ   [NUM_CH];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gCh
    always_ff @(posedge clk) begin
      if (!rstN) begin
        offsetQ[ch] <= '0;
        gainQ[ch]   <= GAIN_INIT;
      end else if (wrChan == ch) begin
        if (strb.wrOffset) offsetQ[ch] <= wrData;
        if (strb.wrGain)   gainQ[ch]   <= wrData;
      end
    end
  end

  assign rdOffset = offsetQ[rdChan];
  assign rdGain   = gainQ[rdChan];
endmodule

// File: rtl/calSequencer.sv
module calSequencer
  import calSeqPkg::*;
#(
  parameter int NUM_CH        = 4,
  parameter int DATA_W        = 24,
  parameter int CHOP_PERIODS  = 22,
  parameter int PLAIN_PERIODS = 24,
  localparam int CH_W         = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeWrEn,
  input  logic [2:0]        modeWrData,
  input  logic              modTick,
  input  logic              chopEn,
  input  logic [CH_W-1:0]   chanSel,
  input  logic              filtValid,
  input  logic [DATA_W-1:0] filtData,
  input  logic [CH_W-1:0]   rdChan,
  output logic [2:0]        mode,
  output logic              rdy,
  output logic [DATA_W-1:0] rdOffset,
  output logic [DATA_W-1:0] rdGain
);
  coefStrobeT      strb;
  logic [CH_W-1:0] calChan;

  calCtrl #(
    .CH_W(CH_W), .CHOP_PERIODS(CHOP_PERIODS), .PLAIN_PERIODS(PLAIN_PERIODS)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .modeWrEn(modeWrEn), .modeWrData(modeWrData),
    .modTick(modTick), .chopEn(chopEn), .chanSel(chanSel), .filtValid(filtValid),
    .mode(mode), .rdy(rdy), .calChan(calChan), .strb(strb)
  );

  calCoefRegs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) uCoef (
    .clk(clk), .rstN(rstN), .strb(strb), .wrChan(calChan), .wrData(filtData),
    .rdChan(rdChan), .rdOffset(rdOffset), .rdGain(rdGain)
  );
endmodule

// File: rtl/calSequencerChk.sv
module calSequencerChk (
  input logic       clk,
  input logic       rstN,
  input logic       modTick,
  input logic [2:0] mode,
  input logic       rdy
);
  AST_RDY_RISES_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdy) |-> $past(modTick)) else $error("rdy rose without tick"); // R3

  AST_RDY_MEANS_CAL_MODE: assert property (@(posedge clk) disable iff (!rstN)
    rdy |-> (mode[2:1] == 2'b10)) else $error("rdy with non-cal mode"); // R3

  AST_END_TO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(rdy) && !$past(modTick)) |-> (mode == 3'b000)) else $error("end not idle"); // R4

  AST_MODE_CHANGE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(mode) |-> ($past(modTick) || $past(rdy))) else $error("mode moved off tick"); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    ($past(mode) == 3'b000 && !$past(modTick)) |-> (mode == 3'b000)) else $error("idle left"); // R7
endmodule

bind calSequencer calSequencerChk uChk (
  .clk(clk), .rstN(rstN), .modTick(modTick), .mode(mode), .rdy(rdy)
);

// File: tb/tb_calSequencer.sv
module tb_calSequencer;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int DW  = 24;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          modeWrEn = 1'b0;
  logic [2:0]    modeWrData = 3'b000;
  logic          modTick = 1'b0;
  logic          chopEn = 1'b1;
  logic [1:0]    chanSel = 2'd0;
  logic          filtValid = 1'b0;
  logic [DW-1:0] filtData = '0;
  logic [1:0]    rdChan = 2'd0;
  logic [2:0]    mode;
  logic          rdy;
  logic [DW-1:0] rdOffset;
  logic [DW-1:0] rdGain;

  calSequencer dut (
    .clk(clk), .rstN(rstN), .modeWrEn(modeWrEn), .modeWrData(modeWrData),
    .modTick(modTick), .chopEn(chopEn), .chanSel(chanSel), .filtValid(filtValid),
    .filtData(filtData), .rdChan(rdChan), .mode(mode), .rdy(rdy),
    .rdOffset(rdOffset), .rdGain(rdGain)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;
  string curReq = "R1";
  bit started = 0;
  int cycles = 0;

  // behavioural reference
  int mMode = 0, mBusy = 0, mPendV = 0, mPendC = 0, mIsGain = 0, mChan = 0, mLen = 24, mCnt = 0;
  int mOff[NCH];
  int mGain[NCH];

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mMode = 0; mBusy = 0; mPendV = 0; mPendC = 0; mCnt = 0;
      for (int i = 0; i < NCH; i++) begin mOff[i] = 0; mGain[i] = 'h800000; end
    end else begin
      if (modTick && mPendV) begin
        mMode = mPendC; mPendV = 0;
        if (mPendC == 4 || mPendC == 5) begin
          mBusy = 1; mIsGain = (mPendC == 5) ? 1 : 0; mChan = chanSel;
          mLen = chopEn ? 22 : 24; mCnt = 0;
        end else mBusy = 0;
      end else if (mBusy != 0 && filtValid) begin
        mCnt++;
        if (mCnt == mLen) begin
          mBusy = 0; mMode = 0;
          if (mIsGain != 0) mGain[mChan] = filtData; else mOff[mChan] = filtData;
        end
      end
      if (modeWrEn) begin mPendV = 1; mPendC = modeWrData; end
    end
  end

  task automatic chk(string req, string what, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (started) begin
    chk(curReq, "mode", mode, mMode);
    chk(curReq, "rdy", rdy, mBusy);
    chk(curReq, "rdOffset", rdOffset, mOff[rdChan]);
    chk(curReq, "rdGain", rdGain, mGain[rdChan]);
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic writeMode(logic [2:0] c);
    modeWrEn = 1'b1; modeWrData = c; step(); modeWrEn = 1'b0;
  endtask

  task automatic tick();
    modTick = 1'b1; step(); modTick = 1'b0;
  endtask

  task automatic strobe(logic [DW-1:0] d);
    filtValid = 1'b1; filtData = d; step(); filtValid = 1'b0; step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) step();
    rstN = 1'b1; started = 1; step();
    // R1 reset state
    curReq = "R1";
    chk("R1", "mode", mode, 0); chk("R1", "rdy", rdy, 0);
    chk("R1", "offset", rdOffset, 0); chk("R1", "gain", rdGain, 'h800000);

    // R7 conversion code stored, no ready; R9 strobe outside cal no effect
    curReq = "R7";
    writeMode(3'b001); step();
    chk("R2", "mode before tick", mode, 0);
    tick();
    chk("R7", "mode conv", mode, 1); chk("R7", "rdy conv", rdy, 0);
    curReq = "R9";
    strobe(24'h123456);
    chk("R9", "offset untouched", rdOffset, 0);

    // R3/R4/R6 zero-scale, chop on, channel 2
    curReq = "R4";
    chanSel = 2'd2; chopEn = 1'b1; rdChan = 2'd2;
    writeMode(3'b100); step();
    chk("R2", "pending not applied", mode, 1);
    filtValid = 1'b1; filtData = 24'hDEAD00; tick(); filtValid = 1'b0;
    chk("R3", "mode zs", mode, 4); chk("R3", "rdy high", rdy, 1);
    chanSel = 2'd0; chopEn = 1'b0;
    for (int i = 1; i <= 21; i++) strobe(24'h100000 + i);
    chk("R4", "rdy after 21", rdy, 1);
    strobe(24'hABCDEF);
    chk("R4", "rdy after 22", rdy, 0); chk("R4", "mode idle", mode, 0);
    chk("R6", "offset ch2", rdOffset, 24'hABCDEF);
    rdChan = 2'd0; step();
    chk("R6", "offset ch0 clean", rdOffset, 0);
    curReq = "R7";
    repeat (5) tick();
    chk("R7", "no auto conv", mode, 0);

    // R4 chop off, 24 periods, channel 1
    curReq = "R4";
    chanSel = 2'd1; chopEn = 1'b0; rdChan = 2'd1;
    writeMode(3'b100); tick();
    for (int i = 1; i <= 23; i++) strobe(24'h200000 + i);
    chk("R4", "rdy after 23", rdy, 1);
    strobe(24'h0F0F0F);
    chk("R4", "rdy after 24", rdy, 0);
    chk("R4", "offset ch1", rdOffset, 24'h0F0F0F);

    // R5 full-scale, channel 3
    curReq = "R5";
    chanSel = 2'd3; chopEn = 1'b1; rdChan = 2'd3;
    writeMode(3'b101); tick();
    chk("R5", "mode fs", mode, 5);
    for (int i = 1; i <= 22; i++) strobe(24'h300000 + i);
    chk("R5", "gain ch3", rdGain, 24'h300016);
    chk("R5", "offset ch3 kept", rdOffset, 0);

    // R8 abort by conversion write
    curReq = "R8";
    chanSel = 2'd1; rdChan = 2'd1;
    writeMode(3'b100); tick();
    for (int i = 1; i <= 5; i++) strobe(24'h400000 + i);
    writeMode(3'b010);
    chk("R8", "still running before tick", rdy, 1);
    tick();
    chk("R8", "rdy aborted", rdy, 0); chk("R8", "mode new", mode, 2);
    for (int i = 1; i <= 25; i++) strobe(24'h500000 + i);
    chk("R8", "offset ch1 kept", rdOffset, 24'h0F0F0F);

    // R8 restart by a second calibration command
    writeMode(3'b100); tick();
    for (int i = 1; i <= 10; i++) strobe(24'h600000 + i);
    writeMode(3'b101); tick();
    chk("R8", "restart rdy", rdy, 1); chk("R8", "restart mode", mode, 5);
    for (int i = 1; i <= 22; i++) strobe(24'h700000 + i);
    chk("R8", "restart gain ch1", rdGain, 24'h700016);
    chk("R8", "offset untouched", rdOffset, 24'h0F0F0F);

    // R1 reset mid-calibration
    curReq = "R1";
    writeMode(3'b100); tick();
    rstN = 1'b0; step(); rstN = 1'b1; step();
    chk("R1", "rdy after reset", rdy, 0); chk("R1", "mode after reset", mode, 0);
    chk("R1", "gain after reset", rdGain, 'h800000);

    step();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule